// File: doc/BRIEF.md
# Flowthrough Burst SRAM Without Read/Write Turnaround

This block is a synchronous static memory that holds 72-bit words: eight byte lanes, each carrying eight data bits and one parity bit. Reads are flowthrough. The address captured on a clock edge selects the word, and that word appears on the output port in the cycle that follows the same edge. No output register sits in the path. Write data follows its address by one clock. Because of this, a read, a write and a deselect can be issued on consecutive edges in any order, and no idle cycle is needed between them.

The array is split into two banks. The most significant address bit chooses the bank, and each bank has its own active-low select. A load cycle (advance low) captures a new address and command. Each advance cycle that follows steps an internal 2-bit beat counter, up to four beats in total. The counter produces either a linear or an interleaved order inside the aligned group of four words. The burst order is taken from the mode input when the load is captured.

The data bus is bidirectional. It is modelled as separate input, output and output-enable ports, and output-enable low is the high-impedance state.

Top module: `ft_burst_sram`

## Requirements
- R1: After reset, and before any load cycle, the output-enable port `dout_en` is low.
- R2: If a read is loaded at edge N, the addressed word is on `dout` with `dout_en` high in the cycle that follows edge N, provided `oe_n` is low. A load cycle has `advance` = 0, the chip select is active and `we_n` = 1.
- R3: If a write is loaded at edge N (`we_n` = 0), the word is written from `din` at edge N+1. A lane i whose `bw_n[i]` was 0 at the load takes `din[8i+7:8i]` and parity bit `din[64+i]`. Every other lane keeps its old value.
- R4: The cycle is selected only when `cs_n[addr[AW-1]]` is 0. Any other load cycle is a deselect: it writes nothing and leaves `dout_en` low in the next cycle.
- R5: With `mode` = 0 at the load, advance k (k = 1..3) addresses low bits (start + k) mod 4. The upper address bits are unchanged.
- R6: With `mode` = 1 at the load, advance k addresses low bits start XOR k. The upper address bits are unchanged.
- R7: In a burst write, each beat takes its lane mask from `bw_n` at that beat's address edge. It takes its data from `din` one edge later.
- R8: An advance after a deselect, or an advance after the fourth beat, accesses nothing. It writes no word, and `dout_en` stays low in the next cycle.
- R9: Read, write and deselect loads may follow each other on consecutive edges. A read loaded on the same edge that commits a write to the same address returns the new data.
- R10: While `oe_n` is 1, `dout_en` is low whatever the cycle type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the control state (not the array) |
| addr | input | AW | Word address; the top bit selects the bank |
| cs_n | input | 2 | Active-low bank selects, index = bank |
| we_n | input | 1 | Active-low write command at a load |
| bw_n | input | 8 | Active-low byte-lane write enables |
| oe_n | input | 1 | Active-low output enable |
| advance | input | 1 | 1 = step burst, 0 = load new address and command |
| mode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| din | input | 72 | Write data: lanes in [63:0], parity in [71:64] |
| dout | output | 72 | Read data, same layout as din |
| dout_en | output | 1 | High when the block drives the data bus |

## Verification
The assertions check several properties on every cycle:
- `oe_n` high always means a tri-stated bus.
- A deselect or write load is followed by an undriven bus.
- A selected read load is followed by a driven bus unless the output is disabled.
- An advance on the fourth beat, or with no burst open, closes the burst.
- A live advance never changes the upper address bits.

Only the bench scenarios can show data correctness, because that needs a reference array. Those scenarios cover:
- byte-lane and parity merging;
- both burst orders with a mask on one beat;
- a write ignored by the wrong bank select;
- read-after-write on adjacent edges;
- proof that an ignored advance stored nothing.

// File: rtl/ft_burst_sram.sv
module ft_burst_sram #(
  parameter int AW     = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int W     = LANES * (LANE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [1:0]       cs_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             oe_n,
  input  logic             advance,
  input  logic             mode,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic             dout_en
);
  localparam int DEPTH    = 1 << AW;
  localparam int BANK_BIT = AW - 1;
  localparam int DW       = LANES * LANE_W;

  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE} op_t;

  op_t              op_q;
  logic [AW-1:0]    base_q;
  logic [1:0]       beat_q;
  logic             mode_q;
  logic [LANES-1:0] mask_q;
  logic [W-1:0]     mem [DEPTH];

  wire          sel        = !cs_n[addr[BANK_BIT]];
  wire [1:0]    low        = mode_q ? (base_q[1:0] ^ beat_q) : (base_q[1:0] + beat_q);
  wire [AW-1:0] cur_addr   = {base_q[AW-1:2], low};
  wire          burst_live = (op_q != OP_IDLE) && (beat_q != 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      beat_q <= '0;
      mode_q <= 1'b0;
      mask_q <= '0;
    end else if (!advance) begin
      base_q <= addr;
      beat_q <= 2'd0;
      mode_q <= mode;
      if (sel) begin
        op_q   <= we_n ? OP_READ : OP_WRITE;
        mask_q <= we_n ? '0 : ~bw_n;
      end else begin
        op_q   <= OP_IDLE;
        mask_q <= '0;
      end
    end else if (burst_live) begin
      beat_q <= beat_q + 2'd1;
      mask_q <= (op_q == OP_WRITE) ? ~bw_n : '0;
    end else begin
      op_q   <= OP_IDLE;
      mask_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (op_q == OP_WRITE) begin
      for (int i = 0; i < LANES; i++) begin
        if (mask_q[i]) begin
          mem[cur_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
          mem[cur_addr][DW+i]               <= din[DW+i];
        end
      end
    end
  end

  assign dout    = mem[cur_addr];
  assign dout_en = (op_q == OP_READ) && !oe_n;
endmodule

// File: rtl/ft_burst_sram_chk.sv
module ft_burst_sram_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [1:0]    cs_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          advance,
  input logic          dout_en,
  input logic [1:0]    op,
  input logic [1:0]    beat,
  input logic [AW-1:0] cur_addr
);
  a_r10_oe_tristates: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  a_r4_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && cs_n[addr[AW-1]]) |=> !dout_en);

  a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !cs_n[addr[AW-1]] && we_n) |=> (oe_n || dout_en));

  a_r3_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !cs_n[addr[AW-1]] && !we_n) |=> !dout_en);

  a_r8_burst_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && (beat == 2'd3 || op == 2'd0)) |=> (op == 2'd0 && !dout_en));

  a_r5_group_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && op != 2'd0 && beat != 2'd3) |=> $stable(cur_addr[AW-1:2]));
endmodule

bind ft_burst_sram ft_burst_sram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
  .oe_n(oe_n), .advance(advance), .dout_en(dout_en), .op(op_q),
  .beat(beat_q), .cur_addr(cur_addr)
);

// File: tb/ft_burst_sram_test.sv
`timescale 1ns/1ps
module ft_burst_sram_test;
  logic clk = 0, rst_n = 0;
  logic [5:0] addr = 0;
  logic [1:0] cs_n = 2'b11;
  logic we_n = 1, oe_n = 0, advance = 0, mode = 0;
  logic [7:0] bw_n = 8'hFF;
  logic [71:0] din = 0, dout;
  logic dout_en;
  int total = 0, fails = 0;
  bit done = 0;
  logic mode_r = 0;
  logic [71:0] refm [64];

  ft_burst_sram uut (.clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
    .bw_n(bw_n), .oe_n(oe_n), .advance(advance), .mode(mode), .din(din),
    .dout(dout), .dout_en(dout_en));

  always #5 clk = ~clk;

  function automatic logic [71:0] pat(input logic [7:0] s);
    return {s ^ 8'h5A, {8{s}} ^ 64'h0123_4567_89AB_CDEF};
  endfunction

  function automatic logic [71:0] merge(input logic [71:0] o, input logic [71:0] n, input logic [7:0] b);
    logic [71:0] r = o;
    for (int i = 0; i < 8; i++) if (!b[i]) begin
      r[i*8 +: 8] = n[i*8 +: 8];
      r[64+i] = n[64+i];
    end
    return r;
  endfunction

  function automatic logic [5:0] beat_addr(input logic [5:0] s, input logic m, input logic [1:0] k);
    return {s[5:2], m ? (s[1:0] ^ k) : (s[1:0] + k)};
  endfunction

  task automatic step(input logic a, input logic [1:0] c, input logic w, input logic [7:0] b,
                      input logic [5:0] ad, input logic [71:0] d);
    @(negedge clk);
    advance = a; cs_n = c; we_n = w; bw_n = b; addr = ad; din = d; mode = mode_r;
    @(posedge clk); #2;
  endtask

  task automatic do_load(input logic [5:0] ad, input logic w, input logic [7:0] b, input logic [71:0] d);
    step(1'b0, ad[5] ? 2'b01 : 2'b10, w, b, ad, d);
  endtask
  task automatic do_adv(input logic [7:0] b, input logic [71:0] d);
    step(1'b1, 2'b11, 1'b1, b, 6'h00, d);
  endtask
  task automatic do_desel(input logic [71:0] d);
    step(1'b0, 2'b11, 1'b0, 8'h00, 6'h00, d);
  endtask

  task automatic chk_rd(input string tag, input logic [71:0] exp);
    total++;
    if (!(dout_en === 1'b1 && dout === exp)) begin
      fails++;
      $display("FAIL %s: en=%b dout=%h expected en=1 dout=%h", tag, dout_en, dout, exp);
    end
  endtask
  task automatic chk_z(input string tag);
    total++;
    if (dout_en !== 1'b0) begin
      fails++;
      $display("FAIL %s: en=%b expected en=0", tag, dout_en);
    end
  endtask

  task automatic t_reset;
    chk_z("R1 reset idle");
  endtask

  task automatic t_single;
    do_load(6'd5, 1'b0, 8'h00, 72'd0);
    refm[5] = pat(8'd1);
    do_load(6'd5, 1'b1, 8'hFF, pat(8'd1));
    chk_rd("R2 R9 flowthrough read after write", refm[5]);
    do_load(6'd5, 1'b0, 8'hF0, 72'd0);
    chk_z("R3 write load not driven");
    refm[5] = merge(refm[5], pat(8'd2), 8'hF0);
    do_load(6'd5, 1'b1, 8'hFF, pat(8'd2));
    chk_rd("R3 byte lanes and parity merged", refm[5]);
    do_desel(72'd0);
    chk_z("R4 deselect");
  endtask

  task automatic t_bank;
    do_load(6'h22, 1'b0, 8'h00, 72'd0);
    refm[6'h22] = pat(8'd3);
    do_desel(pat(8'd3));
    step(1'b0, 2'b10, 1'b0, 8'h00, 6'h22, 72'd0);
    chk_z("R4 wrong bank select write");
    step(1'b0, 2'b10, 1'b1, 8'hFF, 6'h22, pat(8'd4));
    chk_z("R4 wrong bank select read");
    do_load(6'h22, 1'b1, 8'hFF, pat(8'd4));
    chk_rd("R4 ignored write left word", refm[6'h22]);
    step(1'b0, 2'b01, 1'b1, 8'hFF, 6'h05, 72'd0);
    chk_z("R4 bank0 address with bank1 select");
  endtask

  task automatic t_burst(input logic m, input logic [5:0] ws, input logic [5:0] rs, input string tag);
    mode_r = m;
    for (int p = 0; p < 2; p++) begin
      logic [7:0] mk [4];
      for (int k = 0; k < 4; k++) mk[k] = (p == 1 && k == 2) ? 8'h3C : 8'h00;
      do_load(ws, 1'b0, mk[0], 72'd0);
      for (int k = 1; k < 4; k++) begin
        logic [5:0] a0 = beat_addr(ws, m, 2'(k - 1));
        refm[a0] = merge(refm[a0], pat(8'(16 * p + 8 + k)), mk[k-1]);
        do_adv(mk[k], pat(8'(16 * p + 8 + k)));
      end
      refm[beat_addr(ws, m, 2'd3)] = merge(refm[beat_addr(ws, m, 2'd3)], pat(8'(16 * p + 12)), mk[3]);
      do_desel(pat(8'(16 * p + 12)));
    end
    do_load(rs, 1'b1, 8'hFF, 72'd0);
    chk_rd({tag, " R7 beat0"}, refm[beat_addr(rs, m, 2'd0)]);
    for (int k = 1; k < 4; k++) begin
      do_adv(8'hFF, 72'd0);
      chk_rd($sformatf("%s R7 beat%0d", tag, k), refm[beat_addr(rs, m, 2'(k))]);
    end
    do_adv(8'hFF, 72'd0);
    chk_z({tag, " R8 advance past fourth beat"});
    mode_r = 0;
  endtask

  task automatic t_end;
    do_load(6'h30, 1'b0, 8'h00, 72'd0);
    for (int k = 1; k < 4; k++) begin
      refm[6'h30 + k - 1] = pat(8'(40 + k));
      do_adv(8'h00, pat(8'(40 + k)));
    end
    refm[6'h33] = pat(8'd44);
    do_adv(8'h00, pat(8'd44));
    chk_z("R8 fifth advance on write burst");
    do_adv(8'h00, pat(8'd45));
    do_desel(pat(8'd46));
    do_adv(8'h00, pat(8'd47));
    chk_z("R8 advance after deselect");
    do_adv(8'h00, pat(8'd48));
    for (int k = 0; k < 4; k++) begin
      do_load(6'(6'h30 + k), 1'b1, 8'hFF, 72'd0);
      chk_rd($sformatf("R8 no stray write at beat %0d", k), refm[6'h30 + k]);
    end
  endtask

  task automatic t_oe;
    oe_n = 1;
    do_load(6'h30, 1'b1, 8'hFF, 72'd0);
    chk_z("R10 oe_n high on read");
    @(negedge clk); oe_n = 0; #1;
    chk_rd("R10 oe_n low restores drive", refm[6'h30]);
    oe_n = 0;
  endtask

  task automatic t_b2b;
    do_load(6'd5, 1'b1, 8'hFF, 72'd0);
    chk_rd("R9 read first", refm[5]);
    do_load(6'd6, 1'b0, 8'h00, 72'd0);
    chk_z("R9 write right after read");
    refm[6] = pat(8'd50);
    do_load(6'd6, 1'b1, 8'hFF, pat(8'd50));
    chk_rd("R9 read right after write", refm[6]);
    do_desel(72'd0);
    chk_z("R9 deselect right after read");
    do_load(6'd5, 1'b0, 8'h00, 72'd0);
    refm[5] = pat(8'd51);
    do_load(6'd5, 1'b1, 8'hFF, pat(8'd51));
    chk_rd("R9 deselect write read chain", refm[5]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset;
    @(negedge clk); rst_n = 1;
    t_single;
    t_bank;
    t_burst(1'b0, 6'h0A, 6'h09, "R5 linear");
    t_burst(1'b1, 6'h13, 6'h11, "R6 interleaved");
    t_end;
    t_oe;
    t_b2b;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule